// File: doc/BRIEF.md
# Fractional-Baud Serial Port

A register-mapped asynchronous serial port with one transmitter and one receiver. Software talks to it over a simple 32-bit bus (byte address, write strobe, read strobe, write data, combinational read data). A write to the data offset queues a character for transmission. A read of the data offset returns and removes the oldest received character. A flag word reports whether the transmit side can accept data and whether the receive side holds any.

Bit timing comes from a 16x oversampling tick. The tick period in clock cycles is a 16.6 fixed-point divisor: a 16-bit integer part plus a 6-bit fraction in 1/64 steps. The fraction is spread over successive ticks by an accumulator that lengthens a tick period by one cycle each time the accumulator overflows. Frames have no parity and one stop bit, with 5 to 8 data bits sent LSB first. One line-control bit chooses between a single holding register and a FIFO in each direction.

The global enable and the two per-direction enables gate only the start of a character. A character already on the wire always runs to its stop bit.

Top module: `uart_fracbaud`

## Requirements
- R1: After reset `tx_o` is high, the flag word at offset 0x18 reads 0x10 (bit 4 receive-empty set, bit 5 transmit-full clear), and offsets 0x24, 0x28, 0x2C, 0x30 and 0x44 read zero at all times.
- R2: The oversampling tick period averages `ibrd + fbrd/64` cycles, where `ibrd` is written at 0x24 and `fbrd` at 0x28, and each bit lasts 16 ticks. With `ibrd`=2 and `fbrd`=11 a bit lasts 34.75 cycles. An integer divisor of zero produces no ticks.
- R3: A transmitted frame is one low start bit, then N data bits LSB first, then one high stop bit. N = 5 + line-control bits [6:5] (00→5, 01→6, 10→7, 11→8), with line control at 0x2C. Written data bits at and above N are not sent. A received N-bit character is returned right-aligned in data bits [7:0] with the upper bits zero.
- R4: Line-control bit 4 = 0 gives each direction one holding register. Bit 4 = 1 gives each direction a FIFO of `FIFO_DEPTH` entries. Flag bit 5 is set when the transmit store is full and flag bit 4 is set when the receive store is empty.
- R5: A write to offset 0x00 while flag bit 5 is set is discarded, and that character is never sent.
- R6: A read of offset 0x00 returns the oldest received character in bits [7:0] and its framing-error flag in bit 8, and removes it. While flag bit 4 is set the read returns zero and changes nothing.
- R7: The receiver starts on a falling edge of the synchronised line and checks the line again on the 8th tick. If the line is high there, the start is abandoned. A low pulse shorter than half a bit delivers nothing.
- R8: Each data bit is sampled on the 16th tick after the previous sample point. A low level at the stop-bit sample sets bit 8 of the stored character.
- R9: Control register 0x30 bit 0 is the global enable, bit 8 the transmit enable and bit 9 the receive enable. A direction starts a new character only while both its enable and the global enable are set. Clearing either lets a character in progress finish, and queued transmit data stays queued until re-enabled.
- R10: A write to offset 0x44 (interrupt clear, 11 write-one-to-clear bits) is accepted and changes neither the flag word nor any queued data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; removes a character when aimed at the data offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the address |
| tx_o | output | 1 | Serial transmit line, idle high |
| rx_i | input | 1 | Serial receive line, asynchronous |

## Verification
The bench builds the block with its default parameters: a 4-entry FIFO, a 16-bit integer divisor, a 6-bit fraction and 16x oversampling. It programs a divisor of 2 plus 11/64, which makes a bit about 35 clocks long. That keeps several full frames, a fully loaded transmit FIFO and a transmitter stopped in mid-frame within a short run. The fractional rate is checked by timing a nine-bit low run on the line against 312.75 cycles. It is also checked by a serial monitor that samples at computed bit centres and compares each frame against a scoreboard queue.

// File: rtl/uart_fb_pkg.sv
`timescale 1ns/1ps
package uart_fb_pkg;
  localparam int unsigned OFS_DATA = 32'h00;
  localparam int unsigned OFS_FLAG = 32'h18;
  localparam int unsigned OFS_IBRD = 32'h24;
  localparam int unsigned OFS_FBRD = 32'h28;
  localparam int unsigned OFS_LCTL = 32'h2C;
  localparam int unsigned OFS_CTRL = 32'h30;
  localparam int unsigned OFS_ICLR = 32'h44;

  localparam int FLAG_TXFULL  = 5;
  localparam int FLAG_RXEMPTY = 4;
  localparam int LCTL_FIFO    = 4;
  localparam int LCTL_WLEN    = 5;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_TXE     = 8;
  localparam int CTRL_RXE     = 9;

  localparam int DW   = 8;
  localparam int NB_W = 4;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} ser_state_e;

  typedef struct packed {
    logic          ferr;
    logic [DW-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart_fb_baud.sv
`timescale 1ns/1ps
module uart_fb_baud #(
  parameter int IBRD_W = 16,
  parameter int FBRD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IBRD_W-1:0] ibrd_i,
  input  logic [FBRD_W-1:0] fbrd_i,
  output logic              tick_o
);
  localparam int CW = IBRD_W + 1;

  logic [CW-1:0]     cnt_q, period;
  logic [FBRD_W-1:0] acc_q;
  logic              extra_q, run, wrap;

  assign run    = en_i && (ibrd_i != '0);
  assign period = {1'b0, ibrd_i} + CW'(extra_q);
  assign wrap   = (cnt_q + 1'b1) >= period;
  assign tick_o = run && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (wrap) begin
      cnt_q            <= '0;
      {extra_q, acc_q} <= {1'b0, acc_q} + {1'b0, fbrd_i};
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_fb_fifo.sv
`timescale 1ns/1ps
module uart_fb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         single_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = single_i ? !empty_o : (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/uart_fb_tx.sv
`timescale 1ns/1ps
module uart_fb_tx import uart_fb_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            go_i,
  input  logic            avail_i,
  input  logic [DW-1:0]   data_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic            pop_o,
  output logic            busy_o,
  output logic            tx_o
);
  localparam int TW = $clog2(OSR);

  ser_state_e      st_q;
  logic [TW-1:0]   tc_q;
  logic [DW-1:0]   sh_q;
  logic [NB_W-1:0] nb_q, bn_q;
  logic            last;

  assign last   = tick_i && (tc_q == TW'(OSR-1));
  assign pop_o  = (st_q == S_IDLE) && go_i && avail_i;
  assign busy_o = (st_q != S_IDLE);

  always_comb begin
    unique case (st_q)
      S_START: tx_o = 1'b0;
      S_DATA:  tx_o = sh_q[0];
      default: tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;
      tc_q <= '0;
      sh_q <= '0;
      nb_q <= '0;
      bn_q <= '0;
    end else begin
      if (st_q != S_IDLE && tick_i) tc_q <= last ? '0 : tc_q + 1'b1;
      unique case (st_q)
        S_IDLE: if (pop_o) begin
          sh_q <= data_i;
          nb_q <= nbits_i;
          tc_q <= '0;
          st_q <= S_START;
        end
        S_START: if (last) begin
          bn_q <= '0;
          st_q <= S_DATA;
        end
        S_DATA: if (last) begin
          sh_q <= sh_q >> 1;
          if (bn_q == nb_q - 1'b1) st_q <= S_STOP;
          else                     bn_q <= bn_q + 1'b1;
        end
        default: if (last) st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fb_rx.sv
`timescale 1ns/1ps
module uart_fb_rx import uart_fb_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            go_i,
  input  logic            rx_i,
  input  logic [NB_W-1:0] nbits_i,
  output logic            push_o,
  output rx_word_t        word_o,
  output logic            busy_o
);
  localparam int TW = $clog2(OSR);

  ser_state_e      st_q;
  logic [TW-1:0]   tc_q;
  logic [DW-1:0]   sh_q;
  logic [NB_W-1:0] nb_q, bn_q;
  logic            prev_q, last, mid;

  assign last   = tick_i && (tc_q == TW'(OSR-1));
  assign mid    = tick_i && (tc_q == TW'(OSR/2-1));
  assign busy_o = (st_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      tc_q   <= '0;
      sh_q   <= '0;
      nb_q   <= '0;
      bn_q   <= '0;
      prev_q <= 1'b1;
      push_o <= 1'b0;
      word_o <= '0;
    end else begin
      prev_q <= rx_i;
      push_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (go_i && prev_q && !rx_i) begin
          tc_q <= '0;
          nb_q <= nbits_i;
          st_q <= S_START;
        end
        S_START: if (mid) begin
          tc_q <= '0;
          bn_q <= '0;
          st_q <= rx_i ? S_IDLE : S_DATA;
        end else if (tick_i) tc_q <= tc_q + 1'b1;
        S_DATA: if (last) begin
          tc_q <= '0;
          sh_q <= {rx_i, sh_q[DW-1:1]};
          if (bn_q == nb_q - 1'b1) st_q <= S_STOP;
          else                     bn_q <= bn_q + 1'b1;
        end else if (tick_i) tc_q <= tc_q + 1'b1;
        default: if (last) begin
          tc_q        <= '0;
          st_q        <= S_IDLE;
          push_o      <= 1'b1;
          word_o.ferr <= !rx_i;
          word_o.data <= sh_q >> (NB_W'(DW) - nb_q);
        end else if (tick_i) tc_q <= tc_q + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/uart_fracbaud.sv
`timescale 1ns/1ps
module uart_fracbaud import uart_fb_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 4,
  parameter int IBRD_W     = 16,
  parameter int FBRD_W     = 6,
  parameter int OSR        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tx_o,
  input  logic              rx_i
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
  localparam logic [ADDR_W-1:0] A_IBRD = ADDR_W'(OFS_IBRD);
  localparam logic [ADDR_W-1:0] A_FBRD = ADDR_W'(OFS_FBRD);
  localparam logic [ADDR_W-1:0] A_LCTL = ADDR_W'(OFS_LCTL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic [IBRD_W-1:0] ibrd_q;
  logic [FBRD_W-1:0] fbrd_q;
  logic [1:0]        wlen_q;
  logic              fen_q, en_q, txe_q, rxe_q;
  logic              rx_s1_q, rx_s2_q;

  logic              sel_data, tx_go, rx_go, baud_tick;
  logic              tx_full, tx_empty, tx_pop, tx_busy;
  logic              rx_full, rx_empty, rx_pop, rx_push, rx_busy;
  logic [DW-1:0]     tx_head;
  logic [NB_W-1:0]   nbits;
  rx_word_t          rx_word, rx_head;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[31:16], rx_full};

  assign sel_data = (addr_i == A_DATA);
  assign tx_go    = en_q && txe_q;
  assign rx_go    = en_q && rxe_q;
  assign nbits    = NB_W'(5) + NB_W'(wlen_q);
  assign rx_pop   = rd_en_i && sel_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibrd_q <= '0;
      fbrd_q <= '0;
      wlen_q <= '0;
      fen_q  <= 1'b0;
      en_q   <= 1'b0;
      txe_q  <= 1'b0;
      rxe_q  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_IBRD: ibrd_q <= wdata_i[IBRD_W-1:0];
        A_FBRD: fbrd_q <= wdata_i[FBRD_W-1:0];
        A_LCTL: begin
          wlen_q <= wdata_i[LCTL_WLEN +: 2];
          fen_q  <= wdata_i[LCTL_FIFO];
        end
        A_CTRL: begin
          en_q  <= wdata_i[CTRL_EN];
          txe_q <= wdata_i[CTRL_TXE];
          rxe_q <= wdata_i[CTRL_RXE];
        end
        default: ;  // data handled by the FIFO, interrupt clear has no pending state
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_s1_q <= 1'b1;
      rx_s2_q <= 1'b1;
    end else begin
      rx_s1_q <= rx_i;
      rx_s2_q <= rx_s1_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_DATA) begin
      if (!rx_empty) rdata_o[DW:0] = rx_head;
    end else if (addr_i == A_FLAG) begin
      rdata_o[FLAG_TXFULL]  = tx_full;
      rdata_o[FLAG_RXEMPTY] = rx_empty;
    end
  end

  uart_fb_baud #(.IBRD_W(IBRD_W), .FBRD_W(FBRD_W)) i_baud (
    .clk_i, .rst_ni,
    .en_i   (en_q || tx_busy || rx_busy),
    .ibrd_i (ibrd_q),
    .fbrd_i (fbrd_q),
    .tick_o (baud_tick)
  );

  uart_fb_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) i_txf (
    .clk_i, .rst_ni,
    .single_i (!fen_q),
    .push_i   (wr_en_i && sel_data),
    .din_i    (wdata_i[DW-1:0]),
    .pop_i    (tx_pop),
    .dout_o   (tx_head),
    .full_o   (tx_full),
    .empty_o  (tx_empty)
  );

  uart_fb_fifo #(.W(DW+1), .DEPTH(FIFO_DEPTH)) i_rxf (
    .clk_i, .rst_ni,
    .single_i (!fen_q),
    .push_i   (rx_push),
    .din_i    (rx_word),
    .pop_i    (rx_pop),
    .dout_o   (rx_head),
    .full_o   (rx_full),
    .empty_o  (rx_empty)
  );

  uart_fb_tx #(.OSR(OSR)) i_tx (
    .clk_i, .rst_ni,
    .tick_i  (baud_tick),
    .go_i    (tx_go),
    .avail_i (!tx_empty),
    .data_i  (tx_head),
    .nbits_i (nbits),
    .pop_o   (tx_pop),
    .busy_o  (tx_busy),
    .tx_o    (tx_o)
  );

  uart_fb_rx #(.OSR(OSR)) i_rx (
    .clk_i, .rst_ni,
    .tick_i  (baud_tick),
    .go_i    (rx_go),
    .rx_i    (rx_s2_q),
    .nbits_i (nbits),
    .push_o  (rx_push),
    .word_o  (rx_word),
    .busy_o  (rx_busy)
  );
endmodule

// File: rtl/uart_fracbaud_chk.sv
`timescale 1ns/1ps
module uart_fracbaud_chk #(
  parameter int IBRD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_o,
  input logic              rd_en_i,
  input logic [31:0]       rdata_o,
  input logic              sel_data,
  input logic              rx_empty,
  input logic              tx_busy,
  input logic              rx_busy,
  input logic              tx_go,
  input logic              rx_go,
  input logic              baud_tick,
  input logic [IBRD_W-1:0] ibrd_q
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  a_r2_tick_needs_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick |-> (ibrd_q != '0));

  a_r6_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel_data && rx_empty) |-> (rdata_o == '0));

  a_r9_tx_no_start_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_go && !tx_busy) |=> !tx_busy);

  a_r9_rx_no_start_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_go && !rx_busy) |=> !rx_busy);
endmodule

bind uart_fracbaud uart_fracbaud_chk #(.IBRD_W(IBRD_W)) i_chk (
  .clk_i, .rst_ni, .tx_o, .rd_en_i, .rdata_o, .sel_data, .rx_empty,
  .tx_busy, .rx_busy, .tx_go, .rx_go, .baud_tick, .ibrd_q
);

// File: tb/test_uart_fracbaud.sv
`timescale 1ns/1ps
module test_uart_fracbaud;
  import uart_fb_pkg::*;

  localparam int  ADDR_W = 12;
  localparam int  DEPTH  = 4;
  localparam real BITC   = 16.0 * (2.0 + 11.0/64.0);
  localparam int  RXBIT  = 35;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              tx;
  logic              rx_line = 1'b1;

  int n_chk = 0, n_fail = 0;
  int mon_nb = 8;
  int exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_fracbaud #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH)) i_uart_fracbaud (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx), .rx_i(rx_line)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr_reg(int unsigned a, int unsigned d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(int unsigned a, output int d);
    @(negedge clk);
    addr = ADDR_W'(a); rd = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd = 1'b0;
  endtask

  // driver: queue the expected wire value, then write
  task automatic send(int b);
    exp_q.push_back(b & ((1 << mon_nb) - 1));
    wr_reg(OFS_DATA, b);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic rx_frame(int b, int nb, bit stop);
    @(negedge clk);
    rx_line = 1'b0;
    repeat (RXBIT) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      rx_line = b[k];
      repeat (RXBIT) @(negedge clk);
    end
    rx_line = stop;
    repeat (RXBIT) @(negedge clk);
    rx_line = 1'b1;
    repeat (RXBIT) @(negedge clk);
  endtask

  // monitor: decode frames on tx and compare against the scoreboard
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        int c, nb, v, e;
        c = 0; v = 0; nb = mon_nb;
        for (int k = 0; k <= nb; k++) begin
          int tgt;
          tgt = $rtoi((real'(k) + 1.5) * BITC);
          while (c < tgt) begin @(negedge clk); c++; end
          if (k < nb) v |= int'(tx) << k;
          else chk(tx == 1'b1, "R3", "stop bit level", int'(tx), 1);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R9", "unexpected frame on tx", v, -1);
        end else begin
          e = exp_q.pop_front();
          chk(v == e, "R3", "transmitted character", v, e);
        end
      end
      prev = tx;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int d, f0, n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(tx == 1'b1, "R1", "tx idle after reset", int'(tx), 1);
    rd_reg(OFS_FLAG, d); chk(d == 32'h10, "R1", "flags after reset", d, 32'h10);
    rd_reg(OFS_IBRD, d); chk(d == 0, "R1", "divisor offset reads zero", d, 0);

    wr_reg(OFS_IBRD, 2);
    wr_reg(OFS_FBRD, 11);
    wr_reg(OFS_LCTL, 32'h60);
    wr_reg(OFS_CTRL, 32'h301);
    rd_reg(OFS_CTRL, d); chk(d == 0, "R1", "control offset reads zero", d, 0);

    // R2: nine low bits (start + 8 zeros) = 312.75 cycles
    send(8'h00);
    while (tx) @(negedge clk);
    n = 0;
    while (!tx) begin @(negedge clk); n++; end
    chk(n >= 308 && n <= 317, "R2", "low run of start+8 zero bits", n, 313);
    drain();

    // R4/R5: single holding register
    send(8'hA5);
    repeat (3) @(negedge clk);
    send(8'h3C);
    rd_reg(OFS_FLAG, d); chk(d == 32'h30, "R4", "holding full flag", d, 32'h30);
    wr_reg(OFS_DATA, 8'hFF);  // R5: must be discarded
    drain();
    rd_reg(OFS_FLAG, d); chk(d == 32'h10, "R4", "holding drained flag", d, 32'h10);

    // R4/R5: FIFO mode, 8 bits
    wr_reg(OFS_LCTL, 32'h70);
    for (int i = 0; i <= DEPTH; i++) send(i * 7 + 1);
    rd_reg(OFS_FLAG, d); chk(d == 32'h30, "R4", "fifo full flag", d, 32'h30);
    wr_reg(OFS_DATA, 8'h99);  // R5: must be discarded
    drain();

    // R3: 5-bit words, upper bits dropped
    wr_reg(OFS_LCTL, 32'h10);
    mon_nb = 5;
    send(8'h15);
    send(8'hEA);
    drain();
    mon_nb = 8;
    wr_reg(OFS_LCTL, 32'h70);

    // R6: receive and read
    rx_frame(8'h5A, 8, 1'b1);
    rd_reg(OFS_FLAG, d); chk(d == 32'h00, "R4", "rx not empty flag", d, 32'h00);
    rd_reg(OFS_DATA, d); chk(d == 32'h5A, "R6", "received byte", d, 32'h5A);
    rd_reg(OFS_DATA, d); chk(d == 0, "R6", "read while empty", d, 0);
    rd_reg(OFS_FLAG, d); chk(d == 32'h10, "R6", "empty after read", d, 32'h10);

    // R3: 6-bit receive, right aligned
    wr_reg(OFS_LCTL, 32'h30);
    rx_frame(6'h2B, 6, 1'b1);
    rd_reg(OFS_DATA, d); chk(d == 32'h2B, "R3", "6-bit received char", d, 32'h2B);
    wr_reg(OFS_LCTL, 32'h70);

    // R8: low stop bit
    rx_frame(8'h81, 8, 1'b0);
    rd_reg(OFS_DATA, d); chk(d == 32'h181, "R8", "framing error bit", d, 32'h181);

    // R7: short glitch rejected
    @(negedge clk); rx_line = 1'b0;
    repeat (3) @(negedge clk); rx_line = 1'b1;
    repeat (600) @(negedge clk);
    rd_reg(OFS_FLAG, d); chk(d == 32'h10, "R7", "glitch gives no char", d, 32'h10);

    // R9: receiver disabled
    wr_reg(OFS_CTRL, 32'h101);
    rx_frame(8'h33, 8, 1'b1);
    rd_reg(OFS_FLAG, d); chk(d == 32'h10, "R9", "rx disabled gives no char", d, 32'h10);
    wr_reg(OFS_CTRL, 32'h301);

    // R9: disable in mid-frame, first completes, second held
    send(8'h11);
    wr_reg(OFS_DATA, 8'h22);
    repeat (100) @(negedge clk);
    wr_reg(OFS_CTRL, 32'h0);
    repeat (700) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "frame in flight completed", exp_q.size(), 0);
    chk(tx == 1'b1, "R9", "line idle while disabled", int'(tx), 1);
    exp_q.push_back(8'h22);
    wr_reg(OFS_CTRL, 32'h301);
    drain();

    // R10: interrupt clear has no effect
    wr_reg(OFS_DATA, 8'h44);
    exp_q.push_back(8'h44);
    rx_frame(8'h6C, 8, 1'b1);
    rd_reg(OFS_FLAG, f0);
    wr_reg(OFS_ICLR, 32'h7FF);
    rd_reg(OFS_FLAG, d); chk(d == f0, "R10", "flags after clear write", d, f0);
    rd_reg(OFS_ICLR, d); chk(d == 0, "R10", "clear offset reads zero", d, 0);
    rd_reg(OFS_DATA, d); chk(d == 32'h6C, "R10", "rx data kept", d, 32'h6C);
    drain();

    finish_run();
  end
endmodule